// File: doc/BRIEF.md
# Cartridge Bank Latch and Window Decoder

This block sits between a host's cartridge port and a large paged flash device. The host sees an 8 KiB cartridge window at host address 0x6000–0x7FFF. The block drives the upper address lines of the flash from a bank register. Software picks a bank by storing a byte anywhere in the window, and the stored value becomes the bank number. The window's low address bits go to the flash directly, so the host needs no address arithmetic to switch banks.

A 1 KiB RAM region at 0x7C00–0x7FFF can be placed on top of the last part of the window. Software shows or hides this RAM by writing to a control address. While the RAM is shown, stores in that region go to the RAM and do not disturb the bank. Reset forces bank 0 and hides the RAM, so start-up code and tables only have to live in bank 0.

The host bus is sampled on the block clock. The write strobe is active when `cart_sel_n`, `host_we_n` and a window address all line up. A captured value takes effect at the first clock edge at which the strobe is seen to have ended.

Top module: `cart_bank_latch`

## Requirements
- R1: After reset the bank is 0 and the RAM is hidden. In that state a read of 0x7C00 enables the flash and does not enable the RAM.
- R2: A write strobe of value N to a ROM address in the window changes `flash_bank` at the first clock edge that samples the strobe inactive. `flash_bank` holds its old value for as long as the strobe stays active.
- R3: `flash_bank` always presents the currently latched bank number.
- R4: Only the low 6 bits of the written byte form the bank number. The upper 2 bits are ignored, so 0xFF selects bank 63.
- R5: `flash_ce_n` is low only when `cart_sel_n` is low, `host_we_n` is high, the address is in 0x6000–0x7FFF and the address is not in the shown RAM region.
- R6: A write with `cart_sel_n` high, or a write to an address outside the window, leaves the bank unchanged.
- R7: A write to the control address 0x7BFE sets the RAM visibility to bit 0 of the data, where 1 means shown. This write leaves the bank unchanged.
- R8: While the RAM is shown, any access to 0x7C00–0x7FFF with `cart_sel_n` low drives `ram_ce_n` low and keeps `flash_ce_n` high. `ram_we_n` is low for writes, and such writes leave the bank unchanged.
- R9: While the RAM is hidden, the region 0x7C00–0x7FFF behaves as ROM. Reads there enable the flash, and writes there select a bank.
- R10: If data changes while one strobe is held, the value present in the last active cycle is the one latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; host bus sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Host address bus |
| host_wdata | input | 8 | Host data bus, write direction |
| cart_sel_n | input | 1 | Cartridge select, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_bank | output | 6 | Upper flash address lines (bank number) |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |

## Verification
The bench focuses on when a bank changes. A latch that updated during the strobe would move `flash_bank` mid-write. One that committed a cycle late would give the first access after the strobe the old bank. Held strobes carry changing data, so a design that latched the first value instead of the last would be caught.

The bench also targets the RAM overlay boundary. It stores into 0x7C00–0x7FFF with the RAM shown and then hidden. A design that ignored the visibility bit would either change banks under the RAM or never reach the RAM. Stores with select high, outside the window and at the control address would each expose a decoder that updates the bank too eagerly.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
   // kind of window access seen during a write strobe
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_ROM  = 2'd1,
      ACC_CTRL = 2'd2,
      ACC_RAM  = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/cbl_win_decode.sv
module cbl_win_decode
   import cbl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WIN_SPAN_BITS = 13,
   parameter int RAM_SPAN_BITS = 10,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6000,
   parameter logic [ADDR_W-1:0] RAM_BASE = 16'h7C00,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h7BFE,
   parameter bit RAM_PRESENT = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ram_en_i,
   output logic              in_win_o,
   output logic              ram_hit_o,
   output acc_kind_e         kind_o
);
   logic in_ram_rgn;
   logic ctrl_hit;

   assign in_win_o   = (addr_i[ADDR_W-1:WIN_SPAN_BITS] == WIN_BASE[ADDR_W-1:WIN_SPAN_BITS]);
   assign in_ram_rgn = (addr_i[ADDR_W-1:RAM_SPAN_BITS] == RAM_BASE[ADDR_W-1:RAM_SPAN_BITS]);
   assign ctrl_hit   = (addr_i == CTRL_ADDR);

   generate
      if (RAM_PRESENT) begin : g_ram
         assign ram_hit_o = ram_en_i & in_ram_rgn;
      end else begin : g_noram
         assign ram_hit_o = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!in_win_o)      kind_o = ACC_NONE;
      else if (ctrl_hit)  kind_o = ACC_CTRL;
      else if (ram_hit_o) kind_o = ACC_RAM;
      else                kind_o = ACC_ROM;
   end
endmodule

// File: rtl/cbl_strobe_capture.sv
module cbl_strobe_capture
   import cbl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_i,
   input  acc_kind_e         kind_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              commit_o,
   output acc_kind_e         pend_kind_o,
   output logic [DATA_W-1:0] pend_data_o
);
   logic strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q    <= 1'b0;
         pend_kind_o <= ACC_NONE;
         pend_data_o <= '0;
      end else begin
         strobe_q <= strobe_i;
         if (strobe_i) begin
            pend_kind_o <= kind_i;
            pend_data_o <= data_i;
         end
      end
   end

   // strobe seen to end in this cycle: apply at the coming edge
   assign commit_o = strobe_q & ~strobe_i;
endmodule

// File: rtl/cbl_bank_regs.sv
module cbl_bank_regs
   import cbl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BANK_W = 6,
   parameter bit RAM_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  acc_kind_e         kind_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [BANK_W-1:0] bank_o,
   output logic              ram_en_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              bank_o <= '0;
      else if (commit_i && kind_i == ACC_ROM)  bank_o <= data_i[BANK_W-1:0];
   end

   generate
      if (RAM_PRESENT) begin : g_ram_en
         logic ram_en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               ram_en_q <= 1'b0;
            else if (commit_i && kind_i == ACC_CTRL)  ram_en_q <= data_i[0];
         end
         assign ram_en_o = ram_en_q;
      end else begin : g_no_ram_en
         assign ram_en_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
   import cbl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int BANK_W = 6,
   parameter int WIN_SPAN_BITS = 13,
   parameter int RAM_SPAN_BITS = 10,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'h6000,
   parameter logic [ADDR_W-1:0] RAM_BASE = 16'h7C00,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h7BFE,
   parameter bit RAM_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              cart_sel_n,
   input  logic              host_we_n,
   output logic              flash_ce_n,
   output logic [BANK_W-1:0] flash_bank,
   output logic              ram_ce_n,
   output logic              ram_we_n
);
   localparam int NUM_BANKS = 1 << BANK_W;

   generate
      if (BANK_W > DATA_W) begin : g_bad_bank_w
         $error("bank width exceeds data width");
      end
      if (RAM_SPAN_BITS >= WIN_SPAN_BITS) begin : g_bad_ram_span
         $error("RAM region must be smaller than the window");
      end
      if (CTRL_ADDR[ADDR_W-1:WIN_SPAN_BITS] != WIN_BASE[ADDR_W-1:WIN_SPAN_BITS]) begin : g_bad_ctrl
         $error("control address must lie inside the window");
      end
      if (NUM_BANKS < 2) begin : g_bad_banks
         $error("at least two banks required");
      end
   endgenerate

   logic              in_win;
   logic              ram_hit;
   logic              ram_en;
   logic              wr_strobe;
   logic              commit;
   acc_kind_e         kind;
   acc_kind_e         pend_kind;
   logic [DATA_W-1:0] pend_data;

   cbl_win_decode #(
      .ADDR_W(ADDR_W), .WIN_SPAN_BITS(WIN_SPAN_BITS), .RAM_SPAN_BITS(RAM_SPAN_BITS),
      .WIN_BASE(WIN_BASE), .RAM_BASE(RAM_BASE), .CTRL_ADDR(CTRL_ADDR),
      .RAM_PRESENT(RAM_PRESENT)
   ) dec_i (
      .addr_i(host_addr), .ram_en_i(ram_en),
      .in_win_o(in_win), .ram_hit_o(ram_hit), .kind_o(kind)
   );

   assign wr_strobe = ~cart_sel_n & ~host_we_n & in_win;

   cbl_strobe_capture #(.DATA_W(DATA_W)) cap_i (
      .clk(clk), .rst_n(rst_n), .strobe_i(wr_strobe), .kind_i(kind),
      .data_i(host_wdata), .commit_o(commit),
      .pend_kind_o(pend_kind), .pend_data_o(pend_data)
   );

   cbl_bank_regs #(.DATA_W(DATA_W), .BANK_W(BANK_W), .RAM_PRESENT(RAM_PRESENT)) regs_i (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .kind_i(pend_kind),
      .data_i(pend_data), .bank_o(flash_bank), .ram_en_o(ram_en)
   );

   assign flash_ce_n = ~(~cart_sel_n & host_we_n & in_win & ~ram_hit);
   assign ram_ce_n   = ~(~cart_sel_n & ram_hit);
   assign ram_we_n   = ~(~cart_sel_n & ram_hit & ~host_we_n);
endmodule

// File: rtl/cart_bank_latch_chk.sv
module cart_bank_latch_chk #(
   parameter int BANK_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cart_sel_n,
   input logic              host_we_n,
   input logic              wr_strobe,
   input logic              ram_en,
   input logic              flash_ce_n,
   input logic [BANK_W-1:0] flash_bank,
   input logic              ram_ce_n,
   input logic              ram_we_n
);
   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (flash_bank == '0 && !ram_en));

   p_hold_during_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> $stable(flash_bank));

   p_change_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(flash_bank) |-> ($past(host_we_n, 1) || $past(cart_sel_n, 1) || !$past(wr_strobe, 1))
                               && $past(wr_strobe, 2));

   p_flash_needs_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_ce_n |-> (!cart_sel_n && host_we_n));

   p_ram_excludes_flash_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ram_ce_n && !flash_ce_n));

   p_ram_we_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (!ram_ce_n && !host_we_n && ram_en));
endmodule

bind cart_bank_latch cart_bank_latch_chk #(.BANK_W(BANK_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cart_sel_n(cart_sel_n), .host_we_n(host_we_n),
   .wr_strobe(wr_strobe), .ram_en(ram_en), .flash_ce_n(flash_ce_n),
   .flash_bank(flash_bank), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n)
);

// File: tb/cart_bank_latch_tb_top.sv
module cart_bank_latch_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_addr = 16'h0000;
   logic [7:0]  host_wdata = 8'h00;
   logic        cart_sel_n = 1'b1;
   logic        host_we_n = 1'b1;
   logic        flash_ce_n;
   logic [5:0]  flash_bank;
   logic        ram_ce_n;
   logic        ram_we_n;

   int checks = 0;
   int errors = 0;
   string cur_req = "R3";

   always #4 clk = ~clk;

   cart_bank_latch dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
      .cart_sel_n(cart_sel_n), .host_we_n(host_we_n), .flash_ce_n(flash_ce_n),
      .flash_bank(flash_bank), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n)
   );

   // behavioural reference model
   int m_bank = 0;
   int m_ram = 0;
   int m_prev = 0;
   int m_pdata = 0;
   int m_pkind = 0; // 0 rom, 1 ctrl, 2 ram

   function automatic int in_win(input int a);
      return (a >= 'h6000 && a < 'h8000) ? 1 : 0;
   endfunction
   function automatic int ram_hit(input int a);
      return (m_ram != 0 && a >= 'h7C00 && a < 'h8000) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_bank = 0; m_ram = 0; m_prev = 0;
      end else begin
         int a;
         int act;
         a = int'(host_addr);
         act = (!host_we_n && !cart_sel_n && in_win(a) != 0) ? 1 : 0;
         if (act != 0) begin
            m_pdata = int'(host_wdata);
            if (a == 'h7BFE) m_pkind = 1;
            else if (ram_hit(a) != 0) m_pkind = 2;
            else m_pkind = 0;
         end else if (m_prev != 0) begin
            if (m_pkind == 0) m_bank = m_pdata % 64;
            else if (m_pkind == 1) m_ram = m_pdata % 2;
         end
         m_prev = act;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int a;
         int e_fce;
         int e_rce;
         int e_rwe;
         a = int'(host_addr);
         e_fce = (!cart_sel_n && host_we_n && in_win(a) != 0 && ram_hit(a) == 0) ? 0 : 1;
         e_rce = (!cart_sel_n && ram_hit(a) != 0) ? 0 : 1;
         e_rwe = (!cart_sel_n && ram_hit(a) != 0 && !host_we_n) ? 0 : 1;
         checks++;
         if (int'(flash_bank) != m_bank || int'(flash_ce_n) != e_fce ||
             int'(ram_ce_n) != e_rce || int'(ram_we_n) != e_rwe) begin
            errors++;
            $display("FAIL %s @%0t: bank/fce/rce/rwe actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     cur_req, $time, flash_bank, flash_ce_n, ram_ce_n, ram_we_n,
                     m_bank, e_fce, e_rce, e_rwe);
         end
      end
   end

   task automatic drive(input logic [15:0] a, input logic [7:0] d, input logic we_n, input logic sel_n);
      @(posedge clk);
      #2;
      host_addr = a; host_wdata = d; host_we_n = we_n; cart_sel_n = sel_n;
   endtask

   task automatic idle();
      drive(16'h0000, 8'h00, 1'b1, 1'b1);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      drive(a, d, 1'b0, 1'b0);
      drive(a, d, 1'b0, 1'b0);
      idle();
      idle();
   endtask

   task automatic expect_val(input int act, input int exp, input string req, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: reset state
      cur_req = "R1";
      drive(16'h7C00, 8'h00, 1'b1, 1'b0);
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 0, "R1", "bank after reset");
      expect_val(int'(flash_ce_n), 0, "R1", "flash_ce_n read 0x7C00");
      expect_val(int'(ram_ce_n), 1, "R1", "ram_ce_n read 0x7C00");

      // R2: bank holds during strobe, changes after
      cur_req = "R2";
      drive(16'h6000, 8'h23, 1'b0, 1'b0);
      drive(16'h6000, 8'h23, 1'b0, 1'b0);
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 0, "R2", "bank during strobe");
      idle();
      idle();
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 35, "R2", "bank after strobe");

      // R3/R4: upper data bits ignored
      cur_req = "R4";
      wr(16'h7123, 8'hFF);
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 63, "R4", "bank from 0xFF");
      cur_req = "R3";
      wr(16'h6ABC, 8'h45);
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 5, "R3", "bank from 0x45");

      // R6: no select, or outside window
      cur_req = "R6";
      wr(16'h6000, 8'h00);
      drive(16'h6000, 8'h11, 1'b0, 1'b1);
      drive(16'h6000, 8'h11, 1'b0, 1'b1);
      drive(16'h2000, 8'h12, 1'b0, 1'b0);
      drive(16'h8000, 8'h13, 1'b0, 1'b0);
      idle(); idle();
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 0, "R6", "bank after ignored writes");

      // R5: flash enable qualification
      cur_req = "R5";
      drive(16'h6100, 8'h00, 1'b1, 1'b1);
      @(negedge clk); #1;
      expect_val(int'(flash_ce_n), 1, "R5", "flash_ce_n no select");
      drive(16'h2000, 8'h00, 1'b1, 1'b0);
      @(negedge clk); #1;
      expect_val(int'(flash_ce_n), 1, "R5", "flash_ce_n outside window");
      drive(16'h7FFF, 8'h00, 1'b1, 1'b0);
      @(negedge clk); #1;
      expect_val(int'(flash_ce_n), 0, "R5", "flash_ce_n window read");

      // R7: control write shows RAM, bank unchanged
      cur_req = "R7";
      wr(16'h6000, 8'h09);
      wr(16'h7BFE, 8'h01);
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 9, "R7", "bank after control write");

      // R8: RAM shown
      cur_req = "R8";
      drive(16'h7C10, 8'h00, 1'b1, 1'b0);
      @(negedge clk); #1;
      expect_val(int'(ram_ce_n), 0, "R8", "ram_ce_n read");
      expect_val(int'(flash_ce_n), 1, "R8", "flash_ce_n read");
      drive(16'h7FFF, 8'h2A, 1'b0, 1'b0);
      @(negedge clk); #1;
      expect_val(int'(ram_we_n), 0, "R8", "ram_we_n write");
      idle(); idle();
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 9, "R8", "bank after RAM write");

      // R9: RAM hidden again, region acts as ROM
      cur_req = "R9";
      wr(16'h7BFE, 8'hFE);
      drive(16'h7C10, 8'h00, 1'b1, 1'b0);
      @(negedge clk); #1;
      expect_val(int'(flash_ce_n), 0, "R9", "flash_ce_n hidden RAM read");
      expect_val(int'(ram_ce_n), 1, "R9", "ram_ce_n hidden RAM read");
      wr(16'h7C00, 8'h0C);
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 12, "R9", "bank via RAM region");

      // R10: last value in a held strobe wins
      cur_req = "R10";
      drive(16'h6002, 8'h01, 1'b0, 1'b0);
      drive(16'h6004, 8'h02, 1'b0, 1'b0);
      drive(16'h6006, 8'h1D, 1'b0, 1'b0);
      idle(); idle();
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 29, "R10", "bank after held strobe");

      // R1: reset mid-run restores bank 0 and hides RAM
      cur_req = "R1";
      wr(16'h7BFE, 8'h01);
      @(posedge clk); #2 rst_n = 1'b0;
      @(posedge clk); #2 rst_n = 1'b1;
      drive(16'h7C00, 8'h00, 1'b1, 1'b0);
      @(negedge clk); #1;
      expect_val(int'(flash_bank), 0, "R1", "bank after second reset");
      expect_val(int'(ram_ce_n), 1, "R1", "RAM hidden after second reset");

      idle(); idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule